// File: doc/BRIEF.md
# System bus address and command steering unit

This block sits between a CPU local bus and two kinds of expansion slot (a wide slot and a narrow 8-bit slot). It moves the upper address bits, the memory/IO qualifier and the bus-high-enable between the two sides. Active-low read and write command strobes are turned around under a direction control. A DRAM refresh cycle can take over every memory-read strobe. Each bidirectional pin appears as three ports: an input, an output and an active-high output enable. The pad ring or an external buffer resolves them.

An address latch strobe captures the narrow-slot address bits, the memory/IO qualifier and the bus-high-enable. The latch is transparent while the strobe is high. It is modelled as a clocked register with a bypass path, so the design stays in one clock domain. There is no data stream through this block. Every pin is a plain control or address level, so there is no valid/ready handshake and no back-pressure. The controls take effect in the same cycle.

Top module: `bus_steer`

## Requirements
- R1: With `addr_dir` high, `la_o` equals `cpu_addr_i`, `la_oe`=1 and `cpu_addr_oe`=0. With it low, `cpu_addr_o` equals `la_i`, `cpu_addr_oe`=1 and `la_oe`=0. An address output that is not enabled reads all zeros.
- R2: With `sa_en_n` low, `sa_o` equals `cpu_addr_i[2:0]` (address bits 19..17) and `sa_oe`=1. This holds whatever `lat_en_n` is, so the direct path has priority.
- R3: While `ale` is high, the latch output follows its live inputs in the same cycle. The inputs are `cpu_addr_i[2:0]`, `cpu_mio_i` and `cpu_bhe_n_i`.
- R4: While `ale` is low, the latch output holds the inputs sampled at the last rising clock edge at which `ale` was high.
- R5: With `sa_en_n` high and `lat_en_n` low, `sa_o` equals the latched address bits and `sa_oe`=1. With both high, `sa_oe`=0 and `sa_o`=0. With `lat_en_n` low, `buf_mio_o` and `sys_bhe_n_o` carry the latched qualifier and bus-high-enable with their enables at 1. Otherwise both enables are 0 and both outputs are 0.
- R6: Command strobe vectors are ordered [0]=memory read, [1]=memory write, [2]=IO read, [3]=IO write, all active low. With `cmd_dir` high, `int_cmd_o` equals `cpu_cmd_i` with `int_cmd_oe`=4'hF. With it low, `cpu_cmd_o` equals `int_cmd_i` with `cpu_cmd_oe`=4'hF.
- R7: With `s8_en_n` low, `s8_memw_n_o` and `s8_memr_n_o` carry the memory write and read strobes from the driving side chosen by `cmd_dir`, and `s8_oe`=2'b11 ([0]=read, [1]=write).
- R8: With `rfc_n` low, bit 0 of `cpu_cmd_o`, bit 0 of `int_cmd_o` and `s8_memr_n_o` all equal `rf_memr_n`, and their enables are 1. This overrides `cmd_dir` and `s8_en_n`.
- R9: An active-low `rst_n` clears the latch to zero.
- R10: A command strobe output that is not enabled reads 1 (inactive) with its enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address latch |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_dir | input | 1 | Upper address direction: 1 = CPU to system |
| cpu_addr_i | input | 7 | CPU address bits 23..17, pin input |
| cpu_addr_o | output | 7 | CPU address bits, pin output |
| cpu_addr_oe | output | 1 | CPU address output enable |
| la_i | input | 7 | Unlatched system address 23..17, pin input |
| la_o | output | 7 | Unlatched system address, pin output |
| la_oe | output | 1 | Unlatched system address output enable |
| sa_en_n | input | 1 | Direct narrow-slot address enable, active low |
| ale | input | 1 | Address latch strobe, transparent high |
| lat_en_n | input | 1 | Latched output enable, active low |
| cpu_mio_i | input | 1 | CPU memory/IO qualifier |
| cpu_bhe_n_i | input | 1 | CPU bus-high-enable, active low |
| sa_o | output | 3 | Narrow-slot address bits 19..17 |
| sa_oe | output | 1 | Narrow-slot address output enable |
| buf_mio_o | output | 1 | Latched memory/IO qualifier |
| buf_mio_oe | output | 1 | Enable for buf_mio_o |
| sys_bhe_n_o | output | 1 | Latched system bus-high-enable |
| sys_bhe_oe | output | 1 | Enable for sys_bhe_n_o |
| cmd_dir | input | 1 | Command direction: 1 = CPU side drives internal side |
| cpu_cmd_i | input | 4 | CPU-side strobes, pin input |
| cpu_cmd_o | output | 4 | CPU-side strobes, pin output |
| cpu_cmd_oe | output | 4 | CPU-side strobe enables |
| int_cmd_i | input | 4 | Internal strobes, pin input |
| int_cmd_o | output | 4 | Internal strobes, pin output |
| int_cmd_oe | output | 4 | Internal strobe enables |
| s8_en_n | input | 1 | Narrow-slot memory strobe enable, active low |
| s8_memw_n_o | output | 1 | Narrow-slot memory write strobe |
| s8_memr_n_o | output | 1 | Narrow-slot memory read strobe |
| s8_oe | output | 2 | Narrow-slot strobe enables, [0]=read, [1]=write |
| rfc_n | input | 1 | Refresh takeover, active low |
| rf_memr_n | input | 1 | Refresh memory-read pulse |

## Verification
The bench targets three orderings. The first is `ale` falling followed by a change of the CPU address. A latch that kept following its input would then show the new bits instead of the held ones. The second is both narrow-slot address enables low together; a design with the wrong priority would put stale latched bits on the slot. The third is refresh while `cmd_dir` points either way and `s8_en_n` is high. A design that ranked refresh below the direction control would leave one memory-read pin undriven or driven from the CPU. The bench also checks that released strobes rest at 1. A wrong release value would show up as a spurious active-low command.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int CMD_N    = 4;
  localparam int CMD_MEMR = 0;
  localparam int CMD_MEMW = 1;
  localparam int CMD_IOR  = 2;
  localparam int CMD_IOW  = 3;
  localparam int S8_RD    = 0;
  localparam int S8_WR    = 1;
endpackage

// File: rtl/dir_buf.sv
// One-way-at-a-time buffer between an A side and a B side.
module dir_buf #(
  parameter int W = 4,
  parameter logic REL = 1'b0
) (
  input  logic         a_to_b,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_comb begin
      b_oe[g] = a_to_b;
      a_oe[g] = ~a_to_b;
      b_o[g]  = a_to_b ? a_i[g] : REL;
      a_o[g]  = a_to_b ? REL : b_i[g];
    end
  end
endmodule

// File: rtl/addr_latch.sv
// Clocked model of a transparent-high latch: bypass while open, hold when shut.
module addr_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_i,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held <= '0;
    else if (open_i) held <= d;
  end

  assign q = open_i ? d : held;
endmodule

// File: rtl/cmd_steer.sv
// Command strobe turnaround, narrow-slot memory strobes and refresh takeover.
module cmd_steer
  import steer_pkg::*;
(
  input  logic             cmd_dir,
  input  logic [CMD_N-1:0] cpu_cmd_i,
  input  logic [CMD_N-1:0] int_cmd_i,
  input  logic             s8_en_n,
  input  logic             rfc_n,
  input  logic             rf_memr_n,
  output logic [CMD_N-1:0] cpu_cmd_o,
  output logic [CMD_N-1:0] cpu_cmd_oe,
  output logic [CMD_N-1:0] int_cmd_o,
  output logic [CMD_N-1:0] int_cmd_oe,
  output logic             s8_memw_n_o,
  output logic             s8_memr_n_o,
  output logic [1:0]       s8_oe
);
  logic [CMD_N-1:0] c_o, c_oe, i_o, i_oe;
  logic             memr_src, memw_src;

  dir_buf #(.W(CMD_N), .REL(1'b1)) u_buf (
    .a_to_b (cmd_dir),
    .a_i    (cpu_cmd_i),
    .b_i    (int_cmd_i),
    .a_o    (c_o),
    .a_oe   (c_oe),
    .b_o    (i_o),
    .b_oe   (i_oe)
  );

  always_comb begin
    memr_src = cmd_dir ? cpu_cmd_i[CMD_MEMR] : int_cmd_i[CMD_MEMR];
    memw_src = cmd_dir ? cpu_cmd_i[CMD_MEMW] : int_cmd_i[CMD_MEMW];

    cpu_cmd_o  = c_o;
    cpu_cmd_oe = c_oe;
    int_cmd_o  = i_o;
    int_cmd_oe = i_oe;
    if (!rfc_n) begin
      cpu_cmd_o[CMD_MEMR]  = rf_memr_n;
      cpu_cmd_oe[CMD_MEMR] = 1'b1;
      int_cmd_o[CMD_MEMR]  = rf_memr_n;
      int_cmd_oe[CMD_MEMR] = 1'b1;
    end

    s8_oe[S8_WR] = ~s8_en_n;
    s8_oe[S8_RD] = ~s8_en_n | ~rfc_n;
    s8_memw_n_o  = s8_en_n ? 1'b1 : memw_src;
    if (!rfc_n)        s8_memr_n_o = rf_memr_n;
    else if (!s8_en_n) s8_memr_n_o = memr_src;
    else               s8_memr_n_o = 1'b1;
  end
endmodule

// File: rtl/bus_steer.sv
module bus_steer
  import steer_pkg::*;
#(
  parameter int HI_W = 7,
  parameter int LO_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_dir,
  input  logic [HI_W-1:0]  cpu_addr_i,
  output logic [HI_W-1:0]  cpu_addr_o,
  output logic             cpu_addr_oe,
  input  logic [HI_W-1:0]  la_i,
  output logic [HI_W-1:0]  la_o,
  output logic             la_oe,
  input  logic             sa_en_n,
  input  logic             ale,
  input  logic             lat_en_n,
  input  logic             cpu_mio_i,
  input  logic             cpu_bhe_n_i,
  output logic [LO_W-1:0]  sa_o,
  output logic             sa_oe,
  output logic             buf_mio_o,
  output logic             buf_mio_oe,
  output logic             sys_bhe_n_o,
  output logic             sys_bhe_oe,
  input  logic             cmd_dir,
  input  logic [CMD_N-1:0] cpu_cmd_i,
  output logic [CMD_N-1:0] cpu_cmd_o,
  output logic [CMD_N-1:0] cpu_cmd_oe,
  input  logic [CMD_N-1:0] int_cmd_i,
  output logic [CMD_N-1:0] int_cmd_o,
  output logic [CMD_N-1:0] int_cmd_oe,
  input  logic             s8_en_n,
  output logic             s8_memw_n_o,
  output logic             s8_memr_n_o,
  output logic [1:0]       s8_oe,
  input  logic             rfc_n,
  input  logic             rf_memr_n
);
  localparam int LAT_W = LO_W + 2;

  logic [HI_W-1:0]  c_oe_v, l_oe_v;
  logic [LAT_W-1:0] lat_q;
  logic [LO_W-1:0]  lat_addr;
  logic             lat_mio, lat_bhe_n;

  dir_buf #(.W(HI_W), .REL(1'b0)) u_abuf (
    .a_to_b (addr_dir),
    .a_i    (cpu_addr_i),
    .b_i    (la_i),
    .a_o    (cpu_addr_o),
    .a_oe   (c_oe_v),
    .b_o    (la_o),
    .b_oe   (l_oe_v)
  );
  assign cpu_addr_oe = c_oe_v[0];
  assign la_oe       = l_oe_v[0];

  addr_latch #(.W(LAT_W)) u_lat (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (ale),
    .d      ({cpu_addr_i[LO_W-1:0], cpu_mio_i, cpu_bhe_n_i}),
    .q      (lat_q)
  );
  assign {lat_addr, lat_mio, lat_bhe_n} = lat_q;

  always_comb begin
    if (!sa_en_n) begin
      sa_o  = cpu_addr_i[LO_W-1:0];
      sa_oe = 1'b1;
    end else if (!lat_en_n) begin
      sa_o  = lat_addr;
      sa_oe = 1'b1;
    end else begin
      sa_o  = '0;
      sa_oe = 1'b0;
    end
    buf_mio_oe  = ~lat_en_n;
    sys_bhe_oe  = ~lat_en_n;
    buf_mio_o   = lat_en_n ? 1'b0 : lat_mio;
    sys_bhe_n_o = lat_en_n ? 1'b0 : lat_bhe_n;
  end

  cmd_steer u_cmd (
    .cmd_dir     (cmd_dir),
    .cpu_cmd_i   (cpu_cmd_i),
    .int_cmd_i   (int_cmd_i),
    .s8_en_n     (s8_en_n),
    .rfc_n       (rfc_n),
    .rf_memr_n   (rf_memr_n),
    .cpu_cmd_o   (cpu_cmd_o),
    .cpu_cmd_oe  (cpu_cmd_oe),
    .int_cmd_o   (int_cmd_o),
    .int_cmd_oe  (int_cmd_oe),
    .s8_memw_n_o (s8_memw_n_o),
    .s8_memr_n_o (s8_memr_n_o),
    .s8_oe       (s8_oe)
  );
endmodule

// File: rtl/bus_steer_chk.sv
module bus_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] cpu_addr_i,
  input logic       cpu_addr_oe,
  input logic       la_oe,
  input logic       sa_en_n,
  input logic       lat_en_n,
  input logic       ale,
  input logic [2:0] sa_o,
  input logic [3:0] cpu_cmd_o,
  input logic [3:0] cpu_cmd_oe,
  input logic [3:0] int_cmd_o,
  input logic [3:0] int_cmd_oe,
  input logic       s8_en_n,
  input logic       s8_memr_n_o,
  input logic [1:0] s8_oe,
  input logic       rfc_n,
  input logic       rf_memr_n
);
  AST_ADDR_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_addr_oe && la_oe)); // R1
  AST_SA_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !sa_en_n |-> (sa_o == cpu_addr_i[2:0])); // R2
  AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !lat_en_n && sa_en_n) |-> (sa_o == cpu_addr_i[2:0])); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !lat_en_n && sa_en_n && $past(!ale && !lat_en_n && sa_en_n && rst_n)) |-> $stable(sa_o)); // R4
  AST_CMD_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_cmd_oe & int_cmd_oe & 4'b1110) == 4'b0000)); // R6
  AST_S8_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (s8_en_n && rfc_n) |-> (s8_oe == 2'b00)); // R7
  AST_RFSH_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n)
    !rfc_n |-> (cpu_cmd_o[0] == rf_memr_n && int_cmd_o[0] == rf_memr_n
                && s8_memr_n_o == rf_memr_n && s8_oe[0])); // R8
endmodule

bind bus_steer bus_steer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_addr_oe (cpu_addr_oe),
  .la_oe       (la_oe),
  .sa_en_n     (sa_en_n),
  .lat_en_n    (lat_en_n),
  .ale         (ale),
  .sa_o        (sa_o),
  .cpu_cmd_o   (cpu_cmd_o),
  .cpu_cmd_oe  (cpu_cmd_oe),
  .int_cmd_o   (int_cmd_o),
  .int_cmd_oe  (int_cmd_oe),
  .s8_en_n     (s8_en_n),
  .s8_memr_n_o (s8_memr_n_o),
  .s8_oe       (s8_oe),
  .rfc_n       (rfc_n),
  .rf_memr_n   (rf_memr_n)
);

// File: tb/bus_steer_test.sv
`timescale 1ns/1ps
module bus_steer_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, addr_dir, sa_en_n, ale, lat_en_n, cpu_mio_i, cpu_bhe_n_i;
  logic       cmd_dir, s8_en_n, rfc_n, rf_memr_n;
  logic [6:0] cpu_addr_i, la_i, cpu_addr_o, la_o;
  logic       cpu_addr_oe, la_oe, sa_oe, buf_mio_o, buf_mio_oe, sys_bhe_n_o, sys_bhe_oe;
  logic [2:0] sa_o;
  logic [3:0] cpu_cmd_i, int_cmd_i, cpu_cmd_o, cpu_cmd_oe, int_cmd_o, int_cmd_oe;
  logic       s8_memw_n_o, s8_memr_n_o;
  logic [1:0] s8_oe;

  bus_steer uut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  // model latch contents: {addr[2:0], mio, bhe_n}
  logic [4:0] m_held = 5'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [4:0] q;
    logic [3:0] e_c, e_coe, e_i, e_ioe;
    logic       mr, mw;
    if (!rst_n) m_held = 5'b0;                                   // R9
    q = ale ? {cpu_addr_i[2:0], cpu_mio_i, cpu_bhe_n_i} : m_held;
    // R1
    chk("R1", {la_o, la_oe, cpu_addr_o, cpu_addr_oe},
        addr_dir ? {cpu_addr_i, 1'b1, 7'd0, 1'b0} : {7'd0, 1'b0, la_i, 1'b1});
    // R2 / R3 / R4 / R5
    if (!sa_en_n)       chk("R2", {sa_o, sa_oe}, {cpu_addr_i[2:0], 1'b1});
    else if (!lat_en_n) chk(ale ? "R3" : "R4", {sa_o, sa_oe}, {q[4:2], 1'b1});
    else                chk("R5", {sa_o, sa_oe}, 4'b0000);
    chk("R5", {buf_mio_o, buf_mio_oe, sys_bhe_n_o, sys_bhe_oe},
        lat_en_n ? 4'b0000 : {q[1], 1'b1, q[0], 1'b1});
    // R6 / R10
    e_c = cmd_dir ? 4'hF : int_cmd_i;  e_coe = cmd_dir ? 4'h0 : 4'hF;
    e_i = cmd_dir ? cpu_cmd_i : 4'hF;  e_ioe = cmd_dir ? 4'hF : 4'h0;
    mr = cmd_dir ? cpu_cmd_i[0] : int_cmd_i[0];
    mw = cmd_dir ? cpu_cmd_i[1] : int_cmd_i[1];
    if (!rfc_n) begin
      e_c[0] = rf_memr_n; e_coe[0] = 1'b1; e_i[0] = rf_memr_n; e_ioe[0] = 1'b1;
      chk("R8", {cpu_cmd_o[0], int_cmd_o[0], s8_memr_n_o, s8_oe[0]},
          {rf_memr_n, rf_memr_n, rf_memr_n, 1'b1});
    end
    chk(cmd_dir ? "R10" : "R6", {cpu_cmd_o, cpu_cmd_oe}, {e_c, e_coe});
    chk(cmd_dir ? "R6" : "R10", {int_cmd_o, int_cmd_oe}, {e_i, e_ioe});
    // R7
    if (rfc_n)
      chk("R7", {s8_memw_n_o, s8_memr_n_o, s8_oe},
          s8_en_n ? 4'b1100 : {mw, mr, 2'b11});
    else
      chk("R7", {s8_memw_n_o, s8_oe[1]}, s8_en_n ? 2'b10 : {mw, 1'b1});
    // latch update at the coming rising edge
    if (rst_n && ale) m_held = {cpu_addr_i[2:0], cpu_mio_i, cpu_bhe_n_i};
  endtask

  task automatic drive_rand();
    addr_dir    = 1'($urandom);
    cpu_addr_i  = 7'($urandom);
    la_i        = 7'($urandom);
    sa_en_n     = ($urandom % 4) != 0;
    ale         = ($urandom % 3) == 0;
    lat_en_n    = ($urandom % 4) == 0;
    cpu_mio_i   = 1'($urandom);
    cpu_bhe_n_i = 1'($urandom);
    cmd_dir     = 1'($urandom);
    cpu_cmd_i   = 4'($urandom);
    int_cmd_i   = 4'($urandom);
    s8_en_n     = 1'($urandom);
    rfc_n       = ($urandom % 6) != 0;
    rf_memr_n   = 1'($urandom);
  endtask

  initial begin
    rst_n = 1'b0; drive_rand();
    ale = 1'b0; lat_en_n = 1'b0; sa_en_n = 1'b1;
    repeat (3) begin @(negedge clk); compare(); end              // R9 reset state
    rst_n = 1'b1;
    // R3 then R4: open the latch on 5, close it, move the CPU address
    ale = 1'b1; cpu_addr_i = 7'h05;
    @(negedge clk); compare();
    ale = 1'b0; cpu_addr_i = 7'h02;
    @(negedge clk); compare();
    chk("R4", {29'd0, sa_o}, 32'd5);
    // R2 priority with both enables low
    sa_en_n = 1'b0; lat_en_n = 1'b0; cpu_addr_i = 7'h03;
    @(negedge clk); compare();
    // R8 with both command directions and narrow slot released
    rfc_n = 1'b0; s8_en_n = 1'b1; rf_memr_n = 1'b0;
    for (int d = 0; d < 2; d++) begin
      cmd_dir = d[0];
      @(negedge clk); compare();
    end
    for (int k = 0; k < 4000; k++) begin
      drive_rand();
      @(negedge clk); compare();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule